// File: doc/BRIEF.md
# Dual-Frame Peripheral Bus Bridge

This block puts three CPU-side request ports onto one narrow peripheral bus. The ports are a data write port, a data read port and a program read port. The peripheral bus has a 16-bit address and a 32-bit data path. Two peripheral frames sit behind the bridge. The dual-width frame takes 16-bit and 32-bit transfers. The legacy frame takes only 16-bit transfers. The bridge chooses the frame from fixed address ranges, which are parameters. It drives the select, address, data and strobe lines and sends the result back to the requester with a one-cycle done pulse.

When a request arrives, the bridge grants it by fixed priority. Every peripheral transfer then takes one setup cycle followed by one strobe cycle. A 32-bit request aimed at the legacy frame becomes two 16-bit transfers on consecutive addresses, low half first. The requester sees one done pulse, and only after the second half. A request whose address falls outside both frames completes without touching the bus. A requester holds its request, address, width and write data steady until its done pulse and then drops the request.

Top module: `pbus_bridge`

## Requirements
- R1: When several ports request at once, the data write port is served first, then the data read port, then the program read port. Each transaction finishes before the next one is granted.
- R2: A full 32-bit request address in 0x0800..0x0FFF selects the dual-width frame (`pb_sel_dual`). An address in 0x7000..0x7FFF selects the legacy frame (`pb_sel_legacy`). The two selects are never high together.
- R3: A granted transfer shows one setup cycle, with the select high and both strobes low. It then shows one strobe cycle, with `pb_rd` or `pb_wr` high. The requester's done output pulses for exactly one cycle, in the cycle right after the last strobe. One idle cycle follows, and only the requesting port's done rises.
- R4: A 32-bit access to the dual-width frame is one transfer with `pb_wide` high. On a write, `pb_wdata` carries all 32 bits. On a read, `rd_data` returns all 32 bits of `pb_rdata`.
- R5: A 32-bit access to the legacy frame is two transfers, at address A and then A+1, with `pb_wide` low in both. Write data bits 15:0 go out first on `pb_wdata[15:0]`, then bits 31:16. On a read, the first transfer's `pb_rdata[15:0]` lands in `rd_data[15:0]` and the second in `rd_data[31:16]`. Done rises only after the second transfer.
- R6: A 16-bit access to either frame is one transfer. It drives `pb_wdata` = {16'h0, wdata[15:0]} and returns `rd_data` = {16'h0, pb_rdata[15:0]}, whatever the upper bits of the write data or of `pb_rdata` hold.
- R7: A request outside both frames drives no select and no strobe. Its done pulses in the cycle after the grant. A read that misses returns `rd_data` = 0.
- R8: During a transfer, `pb_addr` is the low 16 bits of the request address, plus 1 for a second half. The program read address is 22 bits and is zero-extended before decoding. Outside transfers `pb_addr` is 0. `pb_wdata` is 0 except during write transfers.
- R9: During reset and right after it, all selects, strobes and done outputs are low, and `pb_addr`, `pb_wdata` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dwr_req | input | 1 | Data write request, held until done |
| dwr_addr | input | 32 | Data write address |
| dwr_wide | input | 1 | Data write is 32-bit (else 16-bit) |
| dwr_wdata | input | 32 | Data write value |
| dwr_done | output | 1 | Data write complete pulse |
| drd_req | input | 1 | Data read request, held until done |
| drd_addr | input | 32 | Data read address |
| drd_wide | input | 1 | Data read is 32-bit |
| drd_done | output | 1 | Data read complete pulse |
| pgm_req | input | 1 | Program read request, held until done |
| pgm_addr | input | 22 | Program read address |
| pgm_wide | input | 1 | Program read is 32-bit |
| pgm_done | output | 1 | Program read complete pulse |
| rd_data | output | 32 | Read result, valid with a read done |
| pb_addr | output | 16 | Peripheral address |
| pb_wdata | output | 32 | Peripheral write data |
| pb_rdata | input | 32 | Peripheral read data, sampled in the strobe cycle |
| pb_rd | output | 1 | Peripheral read strobe |
| pb_wr | output | 1 | Peripheral write strobe |
| pb_wide | output | 1 | 32-bit transfer marker (dual-width frame only) |
| pb_sel_dual | output | 1 | Dual-width frame select |
| pb_sel_legacy | output | 1 | 16-bit-only frame select |

## Verification
The bridge is tried with single requests of every kind: each port, each frame, both widths, and misses. This separates the one-transfer path from the split path and the legacy-frame path from the narrow path. Addresses sit on range edges: 0x0FFF, 0x1000 and 0x6FFF, plus 0x7FFE, where the second half lands on the last word of the legacy frame. Further addresses set bits above bit 15 to show that decoding uses the whole address. Narrow writes carry non-zero upper data, and the bench peripheral returns distinct upper and lower halves, so that a leaked lane shows. Simultaneous requests on two or three ports, with mixed frames and widths, separate the priority order and the per-port done routing from the single-request behaviour.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    parameter int BUS_W   = 32;
    parameter int HALF_W  = BUS_W / 2;
    parameter int PADDR_W = 16;
    parameter int NPORT   = 3;
    parameter int PORT_W  = $clog2(NPORT);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        FR_NONE,
        FR_DUAL,
        FR_LEGACY
    } frame_e;

    typedef struct packed {
        phase_e               phase;
        logic [PORT_W-1:0]    port;
        logic                 write;
        frame_e               frame;
        logic                 wide;
        logic                 hi;
        logic [PADDR_W-1:0]   paddr;
        logic [BUS_W-1:0]     wdata;
        logic [BUS_W-1:0]     rdata;
    } seq_t;
endpackage

// File: rtl/pbus_arbiter.sv
module pbus_arbiter
    import pbus_pkg::*;
#(
    parameter int N   = NPORT,
    parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   req,
    output logic [IDW-1:0] gnt_idx,
    output logic           gnt_any
);
    // Lowest index has highest priority.
    always_comb begin
        gnt_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_idx = IDW'(i);
            end
        end
        gnt_any = |req;
    end
endmodule

// File: rtl/pbus_decode.sv
module pbus_decode
    import pbus_pkg::*;
#(
    parameter int              AW     = 32,
    parameter logic [AW-1:0]   DUAL_LO = 'h0800,
    parameter logic [AW-1:0]   DUAL_HI = 'h0FFF,
    parameter logic [AW-1:0]   LEG_LO  = 'h7000,
    parameter logic [AW-1:0]   LEG_HI  = 'h7FFF
) (
    input  logic [AW-1:0] addr,
    output frame_e        frame
);
    logic in_dual;
    logic in_leg;

    always_comb begin
        in_dual = (addr >= DUAL_LO) && (addr <= DUAL_HI);
        in_leg  = (addr >= LEG_LO) && (addr <= LEG_HI);
        if (in_dual) begin
            frame = FR_DUAL;
        end else if (in_leg) begin
            frame = FR_LEGACY;
        end else begin
            frame = FR_NONE;
        end
    end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [PORT_W-1:0]   start_port,
    input  logic                start_write,
    input  frame_e              start_frame,
    input  logic                start_wide,
    input  logic [PADDR_W-1:0]  start_paddr,
    input  logic [BUS_W-1:0]    start_wdata,
    input  logic [BUS_W-1:0]    pb_rdata,
    output phase_e              phase,
    output logic [PORT_W-1:0]   cur_port,
    output logic [BUS_W-1:0]    rd_data,
    output logic [PADDR_W-1:0]  pb_addr,
    output logic [BUS_W-1:0]    pb_wdata,
    output logic                pb_rd,
    output logic                pb_wr,
    output logic                pb_wide,
    output logic                pb_sel_dual,
    output logic                pb_sel_legacy
);
    seq_t s_d, s_q;
    logic active;
    logic strobe;
    logic sel_any;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.port  = start_port;
                    s_d.write = start_write;
                    s_d.frame = start_frame;
                    s_d.wide  = start_wide;
                    s_d.hi    = 1'b0;
                    s_d.paddr = start_paddr;
                    s_d.wdata = start_wdata;
                    if (start_frame == FR_NONE) begin
                        s_d.phase = PH_DONE;
                        if (!start_write) begin
                            s_d.rdata = '0;
                        end
                    end else begin
                        s_d.phase = PH_SETUP;
                    end
                end
            end
            PH_SETUP: begin
                s_d.phase = PH_STROBE;
            end
            PH_STROBE: begin
                if (!s_q.write) begin
                    if (s_q.frame == FR_DUAL && s_q.wide) begin
                        s_d.rdata = pb_rdata;
                    end else if (s_q.hi) begin
                        s_d.rdata[BUS_W-1:HALF_W] = pb_rdata[HALF_W-1:0];
                    end else begin
                        s_d.rdata = {{HALF_W{1'b0}}, pb_rdata[HALF_W-1:0]};
                    end
                end
                if (s_q.frame == FR_LEGACY && s_q.wide && !s_q.hi) begin
                    s_d.hi    = 1'b1;
                    s_d.phase = PH_SETUP;
                end else begin
                    s_d.phase = PH_DONE;
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, frame: FR_NONE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        active        = (s_q.phase == PH_SETUP) || (s_q.phase == PH_STROBE);
        strobe        = (s_q.phase == PH_STROBE);
        pb_sel_dual   = active && (s_q.frame == FR_DUAL);
        pb_sel_legacy = active && (s_q.frame == FR_LEGACY);
        pb_rd         = strobe && !s_q.write;
        pb_wr         = strobe && s_q.write;
        pb_wide       = pb_sel_dual && s_q.wide;
        pb_addr       = active ? (s_q.paddr + PADDR_W'(s_q.hi)) : '0;
        if (active && s_q.write) begin
            if (pb_wide) begin
                pb_wdata = s_q.wdata;
            end else if (s_q.hi) begin
                pb_wdata = {{HALF_W{1'b0}}, s_q.wdata[BUS_W-1:HALF_W]};
            end else begin
                pb_wdata = {{HALF_W{1'b0}}, s_q.wdata[HALF_W-1:0]};
            end
        end else begin
            pb_wdata = '0;
        end
        sel_any  = pb_sel_dual || pb_sel_legacy;
        phase    = s_q.phase;
        cur_port = s_q.port;
        rd_data  = s_q.rdata;
    end

    AST_ONE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !(pb_sel_dual && pb_sel_legacy)); // R2

    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_rd || pb_wr) |-> ($past(sel_any) && !$past(pb_rd || pb_wr))); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_rd || pb_wr) |-> $stable(pb_addr)); // R3

    AST_LEGACY_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        pb_sel_legacy |-> !pb_wide); // R5

    AST_DONE_AFTER_STROBE_OR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |-> ($past(pb_rd || pb_wr) || !$past(sel_any))); // R7
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
    import pbus_pkg::*;
#(
    parameter int                ADDR_W  = 32,
    parameter int                PROG_AW = 22,
    parameter logic [ADDR_W-1:0] DUAL_LO = 32'h0000_0800,
    parameter logic [ADDR_W-1:0] DUAL_HI = 32'h0000_0FFF,
    parameter logic [ADDR_W-1:0] LEG_LO  = 32'h0000_7000,
    parameter logic [ADDR_W-1:0] LEG_HI  = 32'h0000_7FFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dwr_req,
    input  logic [ADDR_W-1:0]    dwr_addr,
    input  logic                 dwr_wide,
    input  logic [BUS_W-1:0]     dwr_wdata,
    output logic                 dwr_done,
    input  logic                 drd_req,
    input  logic [ADDR_W-1:0]    drd_addr,
    input  logic                 drd_wide,
    output logic                 drd_done,
    input  logic                 pgm_req,
    input  logic [PROG_AW-1:0]   pgm_addr,
    input  logic                 pgm_wide,
    output logic                 pgm_done,
    output logic [BUS_W-1:0]     rd_data,
    output logic [PADDR_W-1:0]   pb_addr,
    output logic [BUS_W-1:0]     pb_wdata,
    input  logic [BUS_W-1:0]     pb_rdata,
    output logic                 pb_rd,
    output logic                 pb_wr,
    output logic                 pb_wide,
    output logic                 pb_sel_dual,
    output logic                 pb_sel_legacy
);
    localparam int PORT_WR  = 0;
    localparam int PORT_DRD = 1;
    localparam int PORT_PGM = 2;

    logic [NPORT-1:0]  req_vec;
    logic [PORT_W-1:0] gnt_idx;
    logic              gnt_any;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_wide;
    frame_e            sel_frame;
    phase_e            phase;
    logic [PORT_W-1:0] cur_port;
    logic [NPORT-1:0]  done_vec;

    assign req_vec = {pgm_req, drd_req, dwr_req};

    pbus_arbiter #(.N(NPORT), .IDW(PORT_W)) i_arb (
        .req     (req_vec),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    always_comb begin
        unique case (int'(gnt_idx))
            PORT_WR: begin
                sel_addr = dwr_addr;
                sel_wide = dwr_wide;
            end
            PORT_DRD: begin
                sel_addr = drd_addr;
                sel_wide = drd_wide;
            end
            default: begin
                sel_addr = {{(ADDR_W-PROG_AW){1'b0}}, pgm_addr};
                sel_wide = pgm_wide;
            end
        endcase
    end

    pbus_decode #(
        .AW      (ADDR_W),
        .DUAL_LO (DUAL_LO),
        .DUAL_HI (DUAL_HI),
        .LEG_LO  (LEG_LO),
        .LEG_HI  (LEG_HI)
    ) i_dec (
        .addr  (sel_addr),
        .frame (sel_frame)
    );

    pbus_seq i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (gnt_any),
        .start_port    (gnt_idx),
        .start_write   (int'(gnt_idx) == PORT_WR),
        .start_frame   (sel_frame),
        .start_wide    (sel_wide),
        .start_paddr   (sel_addr[PADDR_W-1:0]),
        .start_wdata   (dwr_wdata),
        .pb_rdata      (pb_rdata),
        .phase         (phase),
        .cur_port      (cur_port),
        .rd_data       (rd_data),
        .pb_addr       (pb_addr),
        .pb_wdata      (pb_wdata),
        .pb_rd         (pb_rd),
        .pb_wr         (pb_wr),
        .pb_wide       (pb_wide),
        .pb_sel_dual   (pb_sel_dual),
        .pb_sel_legacy (pb_sel_legacy)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_done
        assign done_vec[g] = (phase == PH_DONE) && (int'(cur_port) == g);
    end

    assign dwr_done = done_vec[PORT_WR];
    assign drd_done = done_vec[PORT_DRD];
    assign pgm_done = done_vec[PORT_PGM];

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_done, drd_done, dwr_done})); // R3

    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && dwr_req) |=> (int'(cur_port) == PORT_WR)); // R1

    AST_DREAD_BEFORE_PGM: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && drd_req && !dwr_req) |=> (int'(cur_port) == PORT_DRD)); // R1
endmodule

// File: tb/test_pbus_bridge.sv
`timescale 1ns/1ps
module test_pbus_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dwr_req = 1'b0, drd_req = 1'b0, pgm_req = 1'b0;
    logic [31:0] dwr_addr = '0, drd_addr = '0, dwr_wdata = '0;
    logic [21:0] pgm_addr = '0;
    logic        dwr_wide = 1'b0, drd_wide = 1'b0, pgm_wide = 1'b0;
    logic        dwr_done, drd_done, pgm_done;
    logic [31:0] rd_data, pb_wdata, pb_rdata;
    logic [15:0] pb_addr;
    logic        pb_rd, pb_wr, pb_wide, pb_sel_dual, pb_sel_legacy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // Bench peripheral: distinct halves derived from the address.
    assign pb_rdata = {~pb_addr, pb_addr ^ 16'hA5A5};

    pbus_bridge i_pbus_bridge (
        .clk(clk), .rst_n(rst_n),
        .dwr_req(dwr_req), .dwr_addr(dwr_addr), .dwr_wide(dwr_wide),
        .dwr_wdata(dwr_wdata), .dwr_done(dwr_done),
        .drd_req(drd_req), .drd_addr(drd_addr), .drd_wide(drd_wide), .drd_done(drd_done),
        .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_wide(pgm_wide), .pgm_done(pgm_done),
        .rd_data(rd_data), .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_rdata(pb_rdata),
        .pb_rd(pb_rd), .pb_wr(pb_wr), .pb_wide(pb_wide),
        .pb_sel_dual(pb_sel_dual), .pb_sel_legacy(pb_sel_legacy)
    );

    typedef struct {
        bit          s1, s2, rd, wr, wd;
        logic [15:0] a;
        logic [31:0] wv;
        logic [2:0]  dn;
        bit          chkr;
        logic [31:0] rv;
        string       tag;
    } exp_t;

    exp_t q[$];

    function automatic exp_t blank(string tag);
        exp_t e;
        e.s1 = 0; e.s2 = 0; e.rd = 0; e.wr = 0; e.wd = 0;
        e.a = '0; e.wv = '0; e.dn = '0; e.chkr = 0; e.rv = '0; e.tag = tag;
        return e;
    endfunction

    function automatic int frame_of(logic [31:0] a);
        if (a >= 32'h0800 && a <= 32'h0FFF) return 1;
        if (a >= 32'h7000 && a <= 32'h7FFF) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] resp(logic [15:0] a);
        return {~a, a ^ 16'hA5A5};
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic add_txn(int port, logic [31:0] addr, bit wide, logic [31:0] wd, string tag);
        exp_t e;
        int f = frame_of(addr);
        logic [15:0] a = addr[15:0];
        bit wr = (port == 0);
        logic [31:0] r0, r1;
        if (f != 0) begin
            int nh = (f == 2 && wide) ? 2 : 1;
            for (int h = 0; h < nh; h++) begin
                e = blank(tag);
                e.s1 = (f == 1); e.s2 = (f == 2); e.wd = (f == 1) && wide;
                e.a = a + 16'(h);
                if (wr) e.wv = (f == 1 && wide) ? wd : {16'h0, (h == 1) ? wd[31:16] : wd[15:0]};
                q.push_back(e);
                e.rd = !wr; e.wr = wr;
                q.push_back(e);
            end
        end
        e = blank(tag);
        e.dn[port] = 1'b1;
        e.chkr = !wr;
        r0 = resp(a);
        r1 = resp(a + 16'd1);
        if (f == 0)                 e.rv = '0;
        else if (f == 1 && wide)    e.rv = r0;
        else if (f == 2 && wide)    e.rv = {r1[15:0], r0[15:0]};
        else                        e.rv = {16'h0, r0[15:0]};
        q.push_back(e);
        q.push_back(blank(tag));
    endtask

    task automatic compare(exp_t e);
        check({pb_sel_dual, pb_sel_legacy} == {e.s1, e.s2}, "R2", "frame selects",
              32'({pb_sel_dual, pb_sel_legacy}), 32'({e.s1, e.s2}));
        check({pb_rd, pb_wr} == {e.rd, e.wr}, "R3", "strobes",
              32'({pb_rd, pb_wr}), 32'({e.rd, e.wr}));
        check(pb_addr == e.a, "R8", "pb_addr", 32'(pb_addr), 32'(e.a));
        check(pb_wide == e.wd, e.tag, "pb_wide", 32'(pb_wide), 32'(e.wd));
        check(pb_wdata == e.wv, e.tag, "pb_wdata", pb_wdata, e.wv);
        check({pgm_done, drd_done, dwr_done} == e.dn, e.tag, "done vector",
              32'({pgm_done, drd_done, dwr_done}), 32'(e.dn));
        if (e.chkr) check(rd_data == e.rv, e.tag, "rd_data", rd_data, e.rv);
    endtask

    task automatic run(bit ew, logic [31:0] aw, bit ww, logic [31:0] dw,
                       bit er, logic [31:0] ar, bit wr_,
                       bit ep, logic [21:0] ap, bit wp, string tag);
        exp_t e;
        q.delete();
        if (ew) add_txn(0, aw, ww, dw, tag);
        if (er) add_txn(1, ar, wr_, 32'h0, tag);
        if (ep) add_txn(2, {10'h0, ap}, wp, 32'h0, tag);
        dwr_req = ew; dwr_addr = aw; dwr_wide = ww; dwr_wdata = dw;
        drd_req = er; drd_addr = ar; drd_wide = wr_;
        pgm_req = ep; pgm_addr = ap; pgm_wide = wp;
        while (q.size() > 0) begin
            @(negedge clk);
            e = q.pop_front();
            compare(e);
            if (e.dn[0]) dwr_req = 1'b0;
            if (e.dn[1]) drd_req = 1'b0;
            if (e.dn[2]) pgm_req = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(blank("R9"));                 // R9 in reset
        check(rd_data == 32'h0, "R9", "rd_data in reset", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        compare(blank("R9"));                 // R9 after reset
        check(rd_data == 32'h0, "R9", "rd_data after reset", rd_data, 32'h0);

        // R4: 32-bit write and read on the dual-width frame
        run(1, 32'h0000_0A10, 1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, "R4");
        run(0, 0, 0, 0, 1, 32'h0000_0A20, 1, 0, 0, 0, "R4");
        // R6: narrow accesses, upper lanes must stay clear
        run(0, 0, 0, 0, 0, 0, 0, 1, 22'h000C00, 0, "R6");
        run(1, 32'h0000_7020, 0, 32'hCAFE_1234, 0, 0, 0, 0, 0, 0, "R6");
        run(0, 0, 0, 0, 1, 32'h0000_0FFF, 0, 0, 0, 0, "R6");
        run(1, 32'h0000_0800, 0, 32'hFFFF_5A5A, 0, 0, 0, 0, 0, 0, "R6");
        // R5: split accesses on the legacy frame
        run(1, 32'h0000_7010, 1, 32'h1234_5678, 0, 0, 0, 0, 0, 0, "R5");
        run(0, 0, 0, 0, 1, 32'h0000_7FFE, 1, 0, 0, 0, "R5");
        run(0, 0, 0, 0, 0, 0, 0, 1, 22'h007200, 1, "R5");
        // R7: misses at range edges and with high address bits set
        run(0, 0, 0, 0, 1, 32'h0000_1000, 1, 0, 0, 0, "R7");
        run(0, 0, 0, 0, 1, 32'h0001_0800, 0, 0, 0, 0, "R7");
        run(1, 32'h0000_6FFF, 1, 32'h0BAD_F00D, 0, 0, 0, 0, 0, 0, "R7");
        run(0, 0, 0, 0, 0, 0, 0, 1, 22'h3F7FFE, 1, "R8");
        // R1: simultaneous requests
        run(1, 32'h0000_7030, 1, 32'hA1B2_C3D4, 1, 32'h0000_0800, 1, 1, 22'h007044, 1, "R1");
        run(0, 0, 0, 0, 1, 32'h0000_0900, 0, 1, 22'h007100, 0, "R1");
        run(1, 32'h0000_1234, 0, 32'h0000_0001, 0, 0, 0, 1, 22'h000E00, 1, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule